// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the part of an SMBus slave that answers the host's alert-response poll. It watches the bus lines, which arrive already synchronized and filtered, and waits for a START condition. The address byte that follows is checked against the alert response address 0001100 with the read bit set. When that byte matches and the local alarm logic reports a pending alert, the block acknowledges. In the following data byte it returns its own 7-bit bus address with a 1 in the least significant bit.

Several devices may answer the same poll. The data byte therefore goes out with open-drain arbitration. The block drives SDA low only for a 0 bit and reads the bus back on every SCL rising edge. If it released the line for a 1 and the bus reads 0, it withdraws at once, so the lowest responding address wins. A responder that sends all eight bits without losing reports the success with a one-cycle pulse. The alarm logic uses that pulse to release its alert pin once its status bits are clear.

The controller has six states. IDLE waits for a START. ADDR shifts in the address byte. ACK holds SDA low for the ninth clock. SEND shifts out the address byte. HOSTACK leaves SDA to the master for its acknowledge. WAIT stays silent until the next START or STOP. Transitions: START (any state) to ADDR; STOP (any state) to IDLE; ADDR to ACK on a matching byte with an alert pending, else ADDR to WAIT; ACK to SEND at the end of the ninth clock; SEND to WAIT on lost arbitration; SEND to HOSTACK after the eighth bit; HOSTACK to WAIT at the rising edge of the master's acknowledge clock.

Top module: `ara_responder`

## Requirements
- R1: While reset is held low, and right after it, the block leaves SDA released (sda_oe_o = 0) and both pulse outputs are low.
- R2: The block drives SDA low for the whole ninth SCL clock only if the 8-bit address byte received MSB first after a START equals 8'h19 (address 0001100, read bit 1) and alert_pending_i is high when that clock begins. Any other byte, or no pending alert, leaves SDA released for the ninth clock and for the rest of the transaction.
- R3: After acknowledging, the block sends the byte {dev_addr_i, 1'b1} MSB first, one bit per SCL clock. It drives SDA low for a 0 bit and releases it for a 1 bit.
- R4: sda_oe_o changes value only while SCL is low.
- R5: If SDA reads 0 at an SCL rising edge during a bit for which the block released the line, arb_lost_o pulses once. SDA then stays released until the next START, and resp_done_o does not pulse in that transaction.
- R6: After the eighth data bit the block releases SDA for the master's acknowledge clock. It pulses resp_done_o for one cycle at that clock's rising edge, whether the master sends ACK or NACK.
- R7: A STOP at any point returns the block to idle with SDA released. A repeated START at any point, including during the data byte, restarts address reception.
- R8: When several responders answer the same poll, the byte on the bus equals {lowest address, 1}. Exactly the lowest-address responder receives resp_done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA bus level (wired-AND result) |
| alert_pending_i | input | 1 | High while the alarm logic has an unserviced alert |
| dev_addr_i | input | 7 | This device's own 7-bit bus address |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| resp_done_o | output | 1 | One-cycle pulse: response byte sent without losing arbitration |
| arb_lost_o | output | 1 | One-cycle pulse: arbitration lost during the response byte |

## Verification
The assertions check, on every cycle, the rules that never depend on the byte values. The SDA drive moves only while SCL is low. A lost arbitration releases the line on the next cycle and never coincides with a success pulse. The success pulse is single and comes with SDA released. A STOP releases the line. Only the bench's scenarios can show the byte-level behaviour. These are: which of all 256 address bytes get an acknowledge, the exact response byte for every own address, the outcome of two responders across many address pairs, and recovery after a STOP or repeated START in mid-transaction.

// File: rtl/ara_pkg.sv
package ara_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_ACK     = 3'd2,
        ST_SEND    = 3'd3,
        ST_HOSTACK = 3'd4,
        ST_WAIT    = 3'd5
    } ara_state_e;

endpackage

// File: rtl/ara_bus_events.sv
module ara_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA moving while SCL stays high marks a START (falling) or STOP (rising)
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/ara_shifter.sv
module ara_shifter #(
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_clr_i,
    input  logic              cnt_inc_i,
    input  logic              rx_en_i,
    input  logic              rx_bit_i,
    input  logic              tx_load_i,
    input  logic [DATA_W-1:0] tx_val_i,
    input  logic              tx_shift_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              tx_msb_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [DATA_W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o     <= '0;
            rx_byte_o <= '0;
            tx_q      <= '1;
        end else begin
            if (cnt_clr_i) begin
                cnt_o <= '0;
            end else if (cnt_inc_i) begin
                cnt_o <= cnt_o + 1'b1;
            end
            if (rx_en_i) begin
                rx_byte_o <= {rx_byte_o[DATA_W-2:0], rx_bit_i};
            end
            if (tx_load_i) begin
                tx_q <= tx_val_i;
            end else if (tx_shift_i) begin
                tx_q <= {tx_q[DATA_W-2:0], 1'b1};
            end
        end
    end

    assign tx_msb_o = tx_q[DATA_W-1];

endmodule

// File: rtl/ara_responder.sv
module ara_responder
    import ara_pkg::*;
#(
    parameter int                ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              alert_pending_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    output logic              sda_oe_o,
    output logic              resp_done_o,
    output logic              arb_lost_o
);

    localparam int                DATA_W   = ADDR_W + 1;
    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [DATA_W-1:0] ARA_BYTE = {ARA_ADDR, 1'b1};
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W);

    ara_state_e state_q, state_d;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic cnt_clr, cnt_inc, rx_en, tx_load, tx_shift;
    logic [DATA_W-1:0] rx_byte;
    logic              tx_msb;
    logic [CNT_W-1:0]  bit_cnt;
    logic              byte_end;
    logic              lost_now;

    ara_bus_events i_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    ara_shifter #(.DATA_W(DATA_W)) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_clr_i  (cnt_clr),
        .cnt_inc_i  (cnt_inc),
        .rx_en_i    (rx_en),
        .rx_bit_i   (sda_i),
        .tx_load_i  (tx_load),
        .tx_val_i   ({dev_addr_i, 1'b1}),
        .tx_shift_i (tx_shift),
        .rx_byte_o  (rx_byte),
        .tx_msb_o   (tx_msb),
        .cnt_o      (bit_cnt)
    );

    assign byte_end = scl_fall && (bit_cnt == LAST_BIT);
    // a released 1 read back as 0 means a lower address is on the bus
    assign lost_now = scl_rise && tx_msb && !sda_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: bus conditions override every state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (byte_end) begin
                        state_d = (rx_byte == ARA_BYTE && alert_pending_i) ? ST_ACK : ST_WAIT;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) state_d = ST_SEND;
                end
                ST_SEND: begin
                    if (lost_now) begin
                        state_d = ST_WAIT;
                    end else if (byte_end) begin
                        state_d = ST_HOSTACK;
                    end
                end
                ST_HOSTACK: begin
                    if (scl_rise) state_d = ST_WAIT;
                end
                ST_WAIT: state_d = ST_WAIT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath strobes
    always_comb begin
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        rx_en       = 1'b0;
        tx_load     = 1'b0;
        tx_shift    = 1'b0;
        sda_oe_o    = 1'b0;
        resp_done_o = 1'b0;
        arb_lost_o  = 1'b0;
        if (start_det) begin
            cnt_clr = 1'b1;
        end
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                rx_en   = scl_rise;
                cnt_inc = scl_rise;
            end
            ST_ACK: begin
                sda_oe_o = 1'b1;
                tx_load  = scl_fall;
                cnt_clr  = scl_fall;
            end
            ST_SEND: begin
                sda_oe_o   = !tx_msb;
                cnt_inc    = scl_rise && !lost_now;
                tx_shift   = scl_fall && (bit_cnt != LAST_BIT);
                arb_lost_o = lost_now && !start_det && !stop_det;
            end
            ST_HOSTACK: begin
                resp_done_o = scl_rise && !start_det && !stop_det;
            end
            ST_WAIT: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/ara_responder_chk.sv
module ara_responder_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_oe_o,
    input logic resp_done_o,
    input logic arb_lost_o
);

    // R4: drive level moves only after SCL was seen low
    a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_i));

    // R5: losing arbitration frees the line on the next cycle
    a_r5_release_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |=> !sda_oe_o);

    // R5: no success credited together with a loss
    a_r5_no_credit_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_o |-> !resp_done_o);

    // R6: the success pulse is a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done_o |=> !resp_done_o);

    // R6: line is released during the master's acknowledge clock
    a_r6_released_at_credit: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done_o |-> !sda_oe_o);

    // R7: a STOP on the bus leaves the line released
    a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o);

endmodule

bind ara_responder ara_responder_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .sda_oe_o    (sda_oe_o),
    .resp_done_o (resp_done_o),
    .arb_lost_o  (arb_lost_o)
);

// File: tb/test_ara_responder.sv
module test_ara_responder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic       rst_n;
    logic       scl;
    logic       m_sda;
    logic       comp_oe;
    logic       pending;
    logic [6:0] dev_addr;
    logic       sda_oe, done, lost;
    logic       sda_bus;

    assign sda_bus = m_sda & ~sda_oe & ~comp_oe;

    ara_responder i_ara_responder (
        .clk             (clk),
        .rst_n           (rst_n),
        .scl_i           (scl),
        .sda_i           (sda_bus),
        .alert_pending_i (pending),
        .dev_addr_i      (dev_addr),
        .sda_oe_o        (sda_oe),
        .resp_done_o     (done),
        .arb_lost_o      (lost)
    );

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int lost_cnt = 0;
    int r4_viol = 0;
    logic prev_oe = 1'b0;

    always @(negedge clk) begin
        if (done === 1'b1) done_cnt++;
        if (lost === 1'b1) lost_cnt++;
        if (rst_n === 1'b1 && sda_oe !== prev_oe && scl === 1'b1) r4_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; wait_n(2);
        scl = 1'b1;   wait_n(2);
        m_sda = 1'b0; wait_n(2);
    endtask

    task automatic send_bit(input bit b);
        scl = 1'b0; comp_oe = 1'b0; wait_n(2);
        m_sda = b;  wait_n(2);
        scl = 1'b1; wait_n(4);
    endtask

    task automatic recv_bit(input bit c_en, input bit c_bit, output bit v);
        scl = 1'b0; wait_n(2);
        comp_oe = c_en & ~c_bit;
        m_sda = 1'b1; wait_n(2);
        scl = 1'b1; wait_n(2);
        v = sda_bus; wait_n(2);
    endtask

    task automatic do_stop();
        scl = 1'b0; wait_n(2);
        comp_oe = 1'b0; m_sda = 1'b0; wait_n(2);
        scl = 1'b1; wait_n(2);
        m_sda = 1'b1; wait_n(4);
    endtask

    // address byte, ack slot, data byte, master NACK, STOP
    task automatic run_body(input logic [7:0] abyte, input bit comp_en, input logic [6:0] comp_addr,
                            output bit acked, output logic [7:0] rd);
        bit v;
        bit act;
        logic [7:0] cbyte;
        for (int i = 7; i >= 0; i--) send_bit(abyte[i]);
        recv_bit(1'b0, 1'b1, v);
        acked = ~v;
        act = comp_en;
        cbyte = {comp_addr, 1'b1};
        for (int i = 7; i >= 0; i--) begin
            recv_bit(act, cbyte[i], v);
            rd[i] = v;
            if (act && cbyte[i] && !v) act = 1'b0;
        end
        send_bit(1'b1);
        do_stop();
        wait_n(4);
    endtask

    task automatic run_txn(input logic [7:0] abyte, input bit comp_en, input logic [6:0] comp_addr,
                           output bit acked, output logic [7:0] rd, output int nd, output int nl);
        int d0;
        int l0;
        d0 = done_cnt;
        l0 = lost_cnt;
        do_start();
        run_body(abyte, comp_en, comp_addr, acked, rd);
        nd = done_cnt - d0;
        nl = lost_cnt - l0;
    endtask

    initial begin
        wait_n(WATCHDOG);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit         acked;
        logic [7:0] rd;
        int         nd;
        int         nl;
        int         d0;
        bit         v;

        rst_n = 1'b0; scl = 1'b1; m_sda = 1'b1; comp_oe = 1'b0;
        pending = 1'b0; dev_addr = 7'h58;
        wait_n(5);
        chk(sda_oe === 1'b0 && done === 1'b0 && lost === 1'b0,
            $sformatf("R1 in reset oe/done/lost act=%b%b%b exp=000", sda_oe, done, lost));
        rst_n = 1'b1;
        wait_n(5);
        chk(sda_oe === 1'b0 && done === 1'b0 && lost === 1'b0,
            $sformatf("R1 after reset oe/done/lost act=%b%b%b exp=000", sda_oe, done, lost));

        // every address byte, alert pending
        pending = 1'b1;
        for (int a = 0; a < 256; a++) begin
            bit exp_ack;
            exp_ack = (a == 8'h19);
            run_txn(8'(a), 1'b0, 7'h0, acked, rd, nd, nl);
            chk(acked == exp_ack, $sformatf("R2 ack for byte %02h act=%0d exp=%0d", a, acked, exp_ack));
            chk(rd == (exp_ack ? 8'hB1 : 8'hFF),
                $sformatf("R3 data for byte %02h act=%02h exp=%02h", a, rd, exp_ack ? 8'hB1 : 8'hFF));
            chk(nd == int'(exp_ack), $sformatf("R6 done count for byte %02h act=%0d exp=%0d", a, nd, exp_ack));
            chk(nl == 0, $sformatf("R5 lost count for byte %02h act=%0d exp=0", a, nl));
        end

        // poll with nothing pending
        pending = 1'b0;
        run_txn(8'h19, 1'b0, 7'h0, acked, rd, nd, nl);
        chk(!acked, $sformatf("R2 no pending ack act=%0d exp=0", acked));
        chk(rd == 8'hFF, $sformatf("R2 no pending data act=%02h exp=ff", rd));
        chk(nd == 0, $sformatf("R2 no pending done act=%0d exp=0", nd));

        // every own address
        pending = 1'b1;
        for (int d = 0; d < 128; d++) begin
            dev_addr = 7'(d);
            run_txn(8'h19, 1'b0, 7'h0, acked, rd, nd, nl);
            chk(acked, $sformatf("R2 ack for dev %02h act=%0d exp=1", d, acked));
            chk(rd == {7'(d), 1'b1}, $sformatf("R3 data for dev %02h act=%02h exp=%02h", d, rd, {7'(d), 1'b1}));
            chk(nd == 1, $sformatf("R6 done for dev %02h act=%0d exp=1", d, nd));
        end

        // two responders: lowest address wins
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                int da;
                int ca;
                int mn;
                da = i * 8 + (i % 8);
                ca = j * 8 + ((j * 3) % 8);
                mn = (da < ca) ? da : ca;
                dev_addr = 7'(da);
                run_txn(8'h19, 1'b1, 7'(ca), acked, rd, nd, nl);
                chk(rd == {7'(mn), 1'b1},
                    $sformatf("R8 bus byte dev=%02h comp=%02h act=%02h exp=%02h", da, ca, rd, {7'(mn), 1'b1}));
                chk(nd == int'(da <= ca),
                    $sformatf("R8 done dev=%02h comp=%02h act=%0d exp=%0d", da, ca, nd, da <= ca));
                chk(nl == int'(da > ca),
                    $sformatf("R5 lost dev=%02h comp=%02h act=%0d exp=%0d", da, ca, nl, da > ca));
            end
        end

        // STOP in the middle of the address byte, then a clean poll
        dev_addr = 7'h58;
        d0 = done_cnt;
        do_start();
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        do_stop();
        wait_n(4);
        chk(sda_oe === 1'b0 && done_cnt == d0,
            $sformatf("R7 after mid-byte stop oe=%b done=%0d exp oe=0 done=0", sda_oe, done_cnt - d0));
        run_txn(8'h19, 1'b0, 7'h0, acked, rd, nd, nl);
        chk(acked && rd == 8'hB1 && nd == 1,
            $sformatf("R7 poll after stop ack=%0d data=%02h done=%0d exp 1/b1/1", acked, rd, nd));

        // repeated START during the first data bit (a released 1)
        d0 = done_cnt;
        do_start();
        for (int i = 7; i >= 0; i--) send_bit(8'h19 >> i);
        recv_bit(1'b0, 1'b1, v);
        chk(!v, $sformatf("R7 first ack before restart act=%0d exp=0", v));
        scl = 1'b0; wait_n(2);
        m_sda = 1'b1; wait_n(2);
        scl = 1'b1; wait_n(2);
        m_sda = 1'b0; wait_n(2);
        run_body(8'h19, 1'b0, 7'h0, acked, rd);
        chk(acked && rd == 8'hB1,
            $sformatf("R7 poll after repeated start ack=%0d data=%02h exp 1/b1", acked, rd));
        chk(done_cnt - d0 == 1, $sformatf("R7 done across restart act=%0d exp=1", done_cnt - d0));

        chk(r4_viol == 0, $sformatf("R4 drive changes while SCL high act=%0d exp=0", r4_viol));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule